// File: doc/BRIEF.md
# Panel power sequencer

This block drives the three power controls of an embedded display panel: panel supply (VDD), video enable and backlight enable. A single power-target bit asks for the panel to be on or off. The block turns that request into a fixed, timed order of steps. Power-up runs supply, then video, then backlight. Power-down runs backlight, then video, then supply. After the supply drops, a mandatory power-cycle lockout must expire before the panel may be powered again.

Delays are held in configuration registers that load through a plain write strobe. There are four delays between steps, counted in fine ticks, and a lockout counted in coarse ticks. Both tick rates come from a free-running divider. A force-VDD bit raises panel supply by itself, without the sequence, so the auxiliary channel can be reached. Status pins report whether the sequence has power applied, which direction the sequence is running, and whether the lockout is in progress. All pins are plain control and status lines. There is no data stream and therefore no valid/ready handshake.

Register map, selected by `cfg_addr`:
- 0: control. Bit 0 is the power target and bit 1 is force-VDD. The write is taken only when bits 31:16 hold the unlock key.
- 1: on-delays. Bits 28:16 hold the power-up delay and bits 12:0 hold the backlight-on delay, both in fine ticks.
- 2: off-delays. Bits 28:16 hold the power-down delay and bits 12:0 hold the backlight-off delay, both in fine ticks.
- 3: divisor. Bits 8 upward hold the fine divider and bits 3:0 hold the lockout length in coarse ticks.

Top module: `pps_sequencer`

## Requirements
- R1: After reset, panel_vdd, video_en and backlight_en are low and stat_on, stat_seq and stat_cycle_busy are all zero (the idle-off state).
- R2: A write to address 0 changes the target and force bits only when wdata[31:16] equals the UNLOCK_KEY parameter (default 16'hA5C3). A write with any other key leaves the outputs unchanged.
- R3: On a power-on request, panel_vdd rises first. video_en follows after the power-up delay (address 1, bits 28:16), and backlight_en follows after the backlight-on delay (address 1, bits 12:0). While powering up, stat_on=1 and stat_seq=01. Once the sequence is fully on, stat_on=1 and stat_seq=00.
- R4: On a power-off request, backlight_en falls first. video_en falls after the backlight-off delay (address 2, bits 12:0), and panel_vdd falls after the power-down delay (address 2, bits 28:16). While powering down, stat_seq=10.
- R5: When panel_vdd falls, the lockout starts. It lasts the count in address 3, bits 3:0, in coarse ticks. During the lockout stat_cycle_busy=1 and panel_vdd stays low. Afterwards the block returns to idle-off.
- R6: A power-on request made during the lockout is held. It starts by itself when the lockout ends, and not before.
- R7: If the target is cleared during the power-up delay, the request takes effect at the end of that step. video_en never rises; the sequence goes straight to the power-down delay and then drops panel_vdd.
- R8: With force-VDD (control bit 1) set and no power target, panel_vdd is high while video_en, backlight_en and all status stay low. Clearing the bit drops panel_vdd.
- R9: A delay of N ends on the N-th tick after its step starts. A delay of zero ends on the first tick.
- R10: A fine tick occurs every (address 3 bits [8 +: DIV_W]) + 1 clocks. A coarse tick occurs once every COARSE_RATIO fine ticks.
- R11: backlight_en is never high without video_en, and video_en is never high without panel_vdd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| panel_vdd | output | 1 | Panel supply enable |
| video_en | output | 1 | Video output enable |
| backlight_en | output | 1 | Backlight enable |
| stat_on | output | 1 | Sequence has panel power applied |
| stat_seq | output | 2 | 00 idle, 01 powering up, 10 powering down or lockout |
| stat_cycle_busy | output | 1 | Power-cycle lockout in progress |

## Verification
The bench builds the block with COARSE_RATIO=4 and writes a fine divider of 3. A fine tick is then four clocks and a coarse tick sixteen. At that scale every step of a full on-off-on sequence, including the lockout, fits into a few hundred cycles. The gap measured between output edges is compared against the tick-window bounds that follow from each delay. Delays of zero, one and several ticks are all within reach, as are a request held through the lockout and a request withdrawn mid power-up.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int DLY_W = 13;
  localparam int CYC_W = 4;

  typedef enum logic [2:0] {
    S_OFF, S_UP, S_BLON, S_ON, S_BLOFF, S_DOWN, S_CYCLE
  } pps_state_e;

  typedef struct packed {
    logic [DLY_W-1:0] up;
    logic [DLY_W-1:0] blon;
    logic [DLY_W-1:0] bloff;
    logic [DLY_W-1:0] pdown;
    logic [CYC_W-1:0] cycle;
  } pps_dly_t;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int          DIV_W      = 16,
  parameter int          RST_DIV    = 4999,
  parameter logic [15:0] UNLOCK_KEY = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  output logic             target,
  output logic             force_vdd,
  output pps_dly_t         dly,
  output logic [DIV_W-1:0] div
);
  localparam int DIV_LSB = 8;

  logic key_ok;
  assign key_ok = (wdata[31:16] == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target    <= 1'b0;
      force_vdd <= 1'b0;
      dly       <= '0;
      div       <= DIV_W'(RST_DIV);
    end else if (we) begin
      case (addr)
        2'd0: if (key_ok) begin
          target    <= wdata[0];
          force_vdd <= wdata[1];
        end
        2'd1: begin
          dly.up   <= wdata[16 +: DLY_W];
          dly.blon <= wdata[0 +: DLY_W];
        end
        2'd2: begin
          dly.pdown <= wdata[16 +: DLY_W];
          dly.bloff <= wdata[0 +: DLY_W];
        end
        default: begin
          div       <= wdata[DIV_LSB +: DIV_W];
          dly.cycle <= wdata[0 +: CYC_W];
        end
      endcase
    end
  end

  // R2: a control write without the key leaves target and force untouched
  p_key_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd0 && wdata[31:16] != UNLOCK_KEY) |=> $stable({target, force_vdd}));
endmodule

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int DIV_W        = 16,
  parameter int COARSE_RATIO = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             fine_tick,
  output logic             coarse_tick
);
  localparam int CR_W = (COARSE_RATIO > 2) ? $clog2(COARSE_RATIO) : 1;

  logic [DIV_W-1:0] fcnt;
  logic [CR_W-1:0]  ccnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt        <= '0;
      ccnt        <= '0;
      fine_tick   <= 1'b0;
      coarse_tick <= 1'b0;
    end else begin
      fine_tick   <= 1'b0;
      coarse_tick <= 1'b0;
      if (fcnt >= div) begin
        fcnt      <= '0;
        fine_tick <= 1'b1;
        if (ccnt == CR_W'(COARSE_RATIO - 1)) begin
          ccnt        <= '0;
          coarse_tick <= 1'b1;
        end else begin
          ccnt <= ccnt + 1'b1;
        end
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R10: every coarse tick coincides with a fine tick
  p_coarse_on_fine_r10: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_tick |-> fine_tick);
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fine_tick,
  input  logic       coarse_tick,
  input  logic       target,
  input  logic       force_vdd,
  input  pps_dly_t   dly,
  output logic       panel_vdd,
  output logic       video_en,
  output logic       backlight_en,
  output logic       st_on,
  output logic [1:0] st_seq,
  output logic       st_cycle
);
  pps_state_e       state, nxt;
  logic [DLY_W-1:0] cnt, load_val;
  logic             load, tick_sel, done, seq_vdd;

  always_comb begin
    tick_sel = (state == S_CYCLE) ? coarse_tick : fine_tick;
    done     = tick_sel && (cnt <= DLY_W'(1));
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    case (state)
      S_OFF: if (target) begin
        nxt = S_UP; load = 1'b1; load_val = dly.up;
      end
      S_UP: if (done) begin
        load = 1'b1;
        if (target) begin nxt = S_BLON; load_val = dly.blon;  end
        else        begin nxt = S_DOWN; load_val = dly.pdown; end
      end
      S_BLON: if (done) begin
        if (target) nxt = S_ON;
        else begin nxt = S_DOWN; load = 1'b1; load_val = dly.pdown; end
      end
      S_ON: if (!target) begin
        nxt = S_BLOFF; load = 1'b1; load_val = dly.bloff;
      end
      S_BLOFF: if (done) begin
        nxt = S_DOWN; load = 1'b1; load_val = dly.pdown;
      end
      S_DOWN: if (done) begin
        nxt = S_CYCLE; load = 1'b1; load_val = DLY_W'(dly.cycle);
      end
      S_CYCLE: if (done) begin
        if (target) begin nxt = S_UP; load = 1'b1; load_val = dly.up; end
        else nxt = S_OFF;
      end
      default: nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (load)                               cnt <= load_val;
      else if (tick_sel && cnt > DLY_W'(1))   cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    seq_vdd      = state inside {S_UP, S_BLON, S_ON, S_BLOFF, S_DOWN};
    video_en     = state inside {S_BLON, S_ON, S_BLOFF};
    backlight_en = (state == S_ON);
    panel_vdd    = seq_vdd || (force_vdd && state != S_CYCLE);
    st_on        = seq_vdd;
    st_cycle     = (state == S_CYCLE);
    if (state inside {S_UP, S_BLON})                 st_seq = 2'b01;
    else if (state inside {S_BLOFF, S_DOWN, S_CYCLE}) st_seq = 2'b10;
    else                                             st_seq = 2'b00;
  end

  // R11: backlight only over live video, video only over a powered panel
  p_bl_over_video_r11: assert property (@(posedge clk) disable iff (!rst_n)
    backlight_en |-> video_en);
  p_video_over_vdd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    video_en |-> panel_vdd);
  // R3: video comes up only once supply was already present
  p_vdd_before_video_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video_en) |-> $past(panel_vdd));
  // R5: lockout is entered only from a powered panel and keeps supply off
  p_lockout_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_cycle) |-> $past(st_on));
  p_lockout_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_cycle |-> !panel_vdd);
endmodule

// File: rtl/pps_sequencer.sv
module pps_sequencer
  import pps_pkg::*;
#(
  parameter int          DIV_W        = 16,
  parameter int          RST_DIV      = 4999,
  parameter int          COARSE_RATIO = 1000,
  parameter logic [15:0] UNLOCK_KEY   = 16'hA5C3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic        panel_vdd,
  output logic        video_en,
  output logic        backlight_en,
  output logic        stat_on,
  output logic [1:0]  stat_seq,
  output logic        stat_cycle_busy
);
  logic             target, force_vdd, fine_tick, coarse_tick;
  logic [DIV_W-1:0] div;
  pps_dly_t         dly;

  pps_regs #(.DIV_W(DIV_W), .RST_DIV(RST_DIV), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .target(target), .force_vdd(force_vdd), .dly(dly), .div(div));

  pps_tick #(.DIV_W(DIV_W), .COARSE_RATIO(COARSE_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div),
    .fine_tick(fine_tick), .coarse_tick(coarse_tick));

  pps_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fine_tick(fine_tick), .coarse_tick(coarse_tick),
    .target(target), .force_vdd(force_vdd), .dly(dly),
    .panel_vdd(panel_vdd), .video_en(video_en), .backlight_en(backlight_en),
    .st_on(stat_on), .st_seq(stat_seq), .st_cycle(stat_cycle_busy));
endmodule

// File: tb/test_pps_sequencer.sv
module test_pps_sequencer;
  localparam logic [15:0] KEY = 16'hA5C3;
  localparam int P  = 4;       // fine tick period in clocks (divider 3)
  localparam int CP = 4 * P;   // coarse tick period (COARSE_RATIO 4)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic panel_vdd, video_en, backlight_en, stat_on, stat_cycle_busy;
  logic [1:0] stat_seq;

  int checks = 0, errors = 0, cyc = 0;
  int t_vdd_r, t_vdd_f, t_vid_r, t_vid_f, t_bl_r, t_bl_f, t_cyc_f;
  int vid_rises = 0, order_viol = 0;
  logic p_vdd = 0, p_vid = 0, p_bl = 0, p_cyc = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  pps_sequencer #(.DIV_W(16), .RST_DIV(3), .COARSE_RATIO(4), .UNLOCK_KEY(KEY)) i_pps_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .panel_vdd(panel_vdd), .video_en(video_en), .backlight_en(backlight_en),
    .stat_on(stat_on), .stat_seq(stat_seq), .stat_cycle_busy(stat_cycle_busy));

  always @(negedge clk) begin
    cyc++;
    if (panel_vdd && !p_vdd) t_vdd_r = cyc;
    if (!panel_vdd && p_vdd) t_vdd_f = cyc;
    if (video_en && !p_vid) begin t_vid_r = cyc; vid_rises++; end
    if (!video_en && p_vid) t_vid_f = cyc;
    if (backlight_en && !p_bl) t_bl_r = cyc;
    if (!backlight_en && p_bl) t_bl_f = cyc;
    if (!stat_cycle_busy && p_cyc) t_cyc_f = cyc;
    if ((backlight_en && !video_en) || (video_en && !panel_vdd)) order_viol++;
    p_vdd = panel_vdd; p_vid = video_en; p_bl = backlight_en; p_cyc = stat_cycle_busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_delays(input int up, input int blon, input int bloff,
                            input int pdown, input int cyc_n);
    wr(2'd1, {3'b0, 13'(up), 3'b0, 13'(blon)});
    wr(2'd2, {3'b0, 13'(pdown), 3'b0, 13'(bloff)});
    wr(2'd3, {8'b0, 16'(P - 1), 4'b0, 4'(cyc_n)});
  endtask

  task automatic wait_sig(input int which, input logic val);
    for (int i = 0; i < 3000; i++) begin
      if ((which == 0 && panel_vdd == val) || (which == 1 && video_en == val) ||
          (which == 2 && backlight_en == val) || (which == 3 && stat_cycle_busy == val))
        return;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!stat_on && stat_seq == 2'b00 && !stat_cycle_busy) return;
      @(negedge clk);
    end
  endtask

  // R1
  task automatic t_reset();
    chk(!panel_vdd && !video_en && !backlight_en, "R1 outputs low", {panel_vdd, video_en, backlight_en}, 0);
    chk(!stat_on && stat_seq == 0 && !stat_cycle_busy, "R1 idle-off status",
        {stat_on, stat_seq, stat_cycle_busy}, 0);
  endtask

  // R2
  task automatic t_bad_key();
    wr(2'd0, {16'h1234, 16'h0001});
    repeat (40) @(negedge clk);
    chk(!panel_vdd && !stat_on, "R2 wrong key ignored", panel_vdd, 0);
  endtask

  // R3, R10
  task automatic t_power_on();
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(0, 1'b1);
    @(negedge clk);
    chk(stat_on && stat_seq == 2'b01, "R3 status powering up", {stat_on, stat_seq}, 3'b101);
    wait_sig(2, 1'b1);
    @(negedge clk);
    chk_rng("R3/R10 vdd->video gap", t_vid_r - t_vdd_r, 2 * P + 1, 3 * P + 1);
    chk_rng("R3 video->backlight gap", t_bl_r - t_vid_r, P + 1, 2 * P + 1);
    chk(stat_on && stat_seq == 2'b00, "R3 status fully on", {stat_on, stat_seq}, 3'b100);
  endtask

  // R4, R5
  task automatic t_power_off();
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(1, 1'b0);
    chk(stat_seq == 2'b10, "R4 status powering down", stat_seq, 2);
    wait_sig(0, 1'b0);
    @(negedge clk);
    chk(t_bl_f < t_vid_f, "R4 backlight off before video", t_bl_f, t_vid_f);
    chk_rng("R4 backlight->video off gap", t_vid_f - t_bl_f, P + 1, 2 * P + 1);
    chk_rng("R4 video->vdd off gap", t_vdd_f - t_vid_f, 1, P + 1);
    chk(stat_cycle_busy && !panel_vdd, "R5 lockout active after vdd off", stat_cycle_busy, 1);
    wait_sig(3, 1'b0);
    @(negedge clk);
    chk_rng("R5 lockout length (coarse)", t_cyc_f - t_vdd_f, CP + 1, 2 * CP + 1);
    chk(!stat_on && stat_seq == 0 && !panel_vdd, "R5 idle-off after lockout", {stat_on, stat_seq}, 0);
  endtask

  // R6
  task automatic t_lock_hold();
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(2, 1'b1);
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(0, 1'b0);
    wr(2'd0, {KEY, 16'h0001});
    repeat (6) @(negedge clk);
    chk(!panel_vdd && stat_cycle_busy, "R6 request held during lockout", panel_vdd, 0);
    wait_sig(0, 1'b1);
    @(negedge clk);
    chk_rng("R6 re-power after lockout", t_vdd_r - t_vdd_f, CP + 1, 2 * CP + 1);
    wait_sig(2, 1'b1);
    wr(2'd0, {KEY, 16'h0000});
    wait_idle();
  endtask

  // R7
  task automatic t_abort();
    int rises0;
    set_delays(10, 2, 2, 1, 0);
    rises0 = vid_rises;
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(0, 1'b1);
    repeat (8) @(negedge clk);
    wr(2'd0, {KEY, 16'h0000});
    wait_sig(0, 1'b0);
    @(negedge clk);
    chk(vid_rises == rises0, "R7 video never enabled", vid_rises - rises0, 0);
    chk_rng("R7 vdd on time = up + down delay", t_vdd_f - t_vdd_r, 9 * P + 1, 11 * P + 2);
    wait_idle();
  endtask

  // R9
  task automatic t_zero();
    set_delays(0, 0, 0, 0, 0);
    wr(2'd0, {KEY, 16'h0001});
    wait_sig(2, 1'b1);
    @(negedge clk);
    chk_rng("R9 zero power-up delay", t_vid_r - t_vdd_r, 1, P + 1);
    chk_rng("R9 zero backlight-on delay", t_bl_r - t_vid_r, 1, P + 1);
    wr(2'd0, {KEY, 16'h0000});
    wait_idle();
  endtask

  // R8
  task automatic t_force();
    wr(2'd0, {KEY, 16'h0002});
    repeat (3) @(negedge clk);
    chk(panel_vdd && !video_en && !backlight_en, "R8 force raises vdd only",
        {panel_vdd, video_en, backlight_en}, 3'b100);
    chk(!stat_on && stat_seq == 0 && !stat_cycle_busy, "R8 status unaffected by force",
        {stat_on, stat_seq, stat_cycle_busy}, 0);
    repeat (20) @(negedge clk);
    chk(!video_en, "R8 no sequence under force", video_en, 0);
    wr(2'd0, {KEY, 16'h0000});
    @(negedge clk);
    chk(!panel_vdd, "R8 clearing force drops vdd", panel_vdd, 0);
  endtask

  task automatic finish_run();
    if (done_flag) return;
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    set_delays(3, 2, 2, 1, 2);
    t_bad_key();
    t_power_on();
    t_power_off();
    t_lock_hold();
    t_abort();
    t_zero();
    t_force();
    chk(order_viol == 0, "R11 output ordering", order_viol, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule